// File: doc/BRIEF.md
# Path-Associative Trace Lookup

This block holds finished instruction traces in a small two-way set-associative array and answers fetch lookups against it. Each lookup presents a start address together with up to three predicted branch directions. The low address bits pick a set. The remaining bits, together with the predicted directions, decide which line answers. Because the directions are matched as part of the tag and never feed the index, several traces that begin at the same address but follow different paths can sit in the two ways of one set at once.

One cycle after a lookup the block reports one of three outcomes. A full hit returns the whole trace. A partial hit returns only the leading part of a trace, up to and including the first branch whose stored direction differs from its prediction. A miss tells the fetch unit to fall back to the ordinary instruction cache. With each hit the block also gives the address to fetch next. A separate write port takes completed traces from a fill unit and picks the way to write.

Top module: `trace_lookup`

## Requirements
- R1: The set index is the low log2(SETS) address bits and the tag is the rest. A lookup finds no line when neither valid way of that set holds its tag. It then reports a miss with count 0, next address 0 and all instruction slots 0.
- R2: The result of a lookup appears on the cycle after it is presented, with res_valid high and exactly one of res_hit, res_partial and res_miss high. On a cycle after no lookup, res_valid and all three flags are low.
- R3: Prediction bit i and stored direction bit i belong to branch i in trace order, and 1 means taken. When every stored branch of a matching line agrees with its prediction, the block signals a full hit. It returns the stored instruction count, with slot i at bits [i*INSN_W +: INSN_W] and every slot at or beyond the count zero.
- R4: When the first disagreement in a matching line is at branch k, the block signals a partial hit and returns count = (position of branch k) + 1. The disagreeing branch is therefore included, and the later slots are zero.
- R5: On a full hit, the next address is the stored target if the last stored branch is the final instruction and is stored taken. It is the stored fall-through address if that branch is stored not taken, and also when no branch ends the line.
- R6: On a partial hit, the next address is the stored alternate address of branch k, which is the path the trace did not follow.
- R7: When both ways match, a full hit beats a partial one. Among equals, the way with more agreeing branches wins, and a tie goes to way 0. res_way reports the chosen way.
- R8: Predictions for branch slots beyond a line's stored branch count have no effect on the result.
- R9: A fill whose tag, set, branch count and stored directions equal those of a valid line overwrites that way and leaves the other way unchanged.
- R10: Any other fill goes to the lowest-numbered invalid way. If both ways are valid, it goes to the least recently used way. Every hit or partial hit and every fill marks the way it touched as most recently used, and a fill takes precedence over a lookup in the same set.
- R11: Reset invalidates every line and clears all result outputs.
- R12: A lookup and a fill in the same cycle: the lookup sees the array as it was before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_addr | input | ADDR_W | Lookup start address |
| lk_pred | input | MAX_BR | Predicted directions, bit i for branch i |
| fill_valid | input | 1 | Write a finished trace |
| fill_addr | input | ADDR_W | Trace start address |
| fill_count | input | log2(MAX_INSN+1) | Instructions in the trace (1..MAX_INSN) |
| fill_nbr | input | log2(MAX_BR+1) | Branches in the trace |
| fill_dirs | input | MAX_BR | Stored directions, bit i for branch i |
| fill_bpos | input | MAX_BR*log2(MAX_INSN) | Slot position of each branch, ascending |
| fill_alt | input | MAX_BR*ADDR_W | Not-followed address of each branch |
| fill_fall | input | ADDR_W | Fall-through address after the line |
| fill_tgt | input | ADDR_W | Taken target of the last branch |
| fill_insns | input | MAX_INSN*INSN_W | Instruction words, slot i at [i*INSN_W +: INSN_W] |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Full hit |
| res_partial | output | 1 | Partial hit |
| res_miss | output | 1 | Miss |
| res_way | output | 1 | Way that answered |
| res_count | output | log2(MAX_INSN+1) | Instructions delivered |
| res_next | output | ADDR_W | Next fetch address |
| res_insns | output | MAX_INSN*INSN_W | Delivered instructions, unused slots zero |

## Verification
The assertions check on every cycle that results have one-cycle latency and carry exactly one outcome flag. They also check that a miss delivers nothing, that a hit delivers at least one instruction, and that each fill leaves its way valid and marks it as most recently used. Only the bench scenarios can show the things that depend on stored contents. These are the prefix cut at the first disagreeing branch, the next-address choice, the preference between competing paths that start at one address, overwrite of an identical path, eviction order under hits, and the read-before-write behaviour of a colliding lookup and fill.

// File: rtl/tc_pkg.sv
// Shared types for the trace lookup block.
package tc_pkg;
    // Outcome of one lookup.
    typedef enum logic [1:0] {
        LK_MISS = 2'd0,
        LK_PART = 2'd1,
        LK_FULL = 2'd2
    } lk_kind_e;
endpackage

// File: rtl/tc_store.sv
// Trace line storage, fill-way choice and per-set LRU state.
// Assumes two ways, SETS a power of two, and fill fields that satisfy the
// fill contract (count 1..MAX_INSN, branch positions ascending and < count).
// A fill takes LRU precedence over a lookup update in the same set.
module tc_store #(
    parameter int ADDR_W   = 16,
    parameter int INSN_W   = 32,
    parameter int MAX_INSN = 16,
    parameter int MAX_BR   = 3,
    parameter int SETS     = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [$clog2(SETS)-1:0]              rd_set,
    input  logic                                 fill_valid,
    input  logic [ADDR_W-1:0]                    fill_addr,
    input  logic [$clog2(MAX_INSN+1)-1:0]        fill_count,
    input  logic [$clog2(MAX_BR+1)-1:0]          fill_nbr,
    input  logic [MAX_BR-1:0]                    fill_dirs,
    input  logic [MAX_BR-1:0][$clog2(MAX_INSN)-1:0] fill_bpos,
    input  logic [MAX_BR-1:0][ADDR_W-1:0]        fill_alt,
    input  logic [ADDR_W-1:0]                    fill_fall,
    input  logic [ADDR_W-1:0]                    fill_tgt,
    input  logic [MAX_INSN-1:0][INSN_W-1:0]      fill_insns,
    input  logic                                 lru_upd,
    input  logic [$clog2(SETS)-1:0]              lru_set,
    input  logic                                 lru_way,
    output logic [1:0]                           rd_vld,
    output logic [1:0][ADDR_W-$clog2(SETS)-1:0]  rd_tag,
    output logic [1:0][$clog2(MAX_INSN+1)-1:0]   rd_cnt,
    output logic [1:0][$clog2(MAX_BR+1)-1:0]     rd_nbr,
    output logic [1:0][MAX_BR-1:0]               rd_dirs,
    output logic [1:0][MAX_BR-1:0][$clog2(MAX_INSN)-1:0] rd_bpos,
    output logic [1:0][MAX_BR-1:0][ADDR_W-1:0]   rd_alt,
    output logic [1:0][ADDR_W-1:0]               rd_fall,
    output logic [1:0][ADDR_W-1:0]               rd_tgt,
    output logic [1:0][MAX_INSN-1:0][INSN_W-1:0] rd_insns
);
    localparam int WAYS    = 2;
    localparam int SET_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - SET_W;
    localparam int CNT_W   = $clog2(MAX_INSN + 1);
    localparam int IDX_W   = $clog2(MAX_INSN);
    localparam int K_W     = $clog2(MAX_BR + 1);
    localparam int ENTRIES = SETS * WAYS;
    localparam int E_W     = SET_W + 1;

    logic [ENTRIES-1:0]                    vld_q;
    logic [SETS-1:0]                       lru_q;
    logic [TAG_W-1:0]                      tag_q  [ENTRIES];
    logic [CNT_W-1:0]                      cnt_q  [ENTRIES];
    logic [K_W-1:0]                        nbr_q  [ENTRIES];
    logic [MAX_BR-1:0]                     dirs_q [ENTRIES];
    logic [MAX_BR-1:0][IDX_W-1:0]          bpos_q [ENTRIES];
    logic [MAX_BR-1:0][ADDR_W-1:0]         alt_q  [ENTRIES];
    logic [ADDR_W-1:0]                     fall_q [ENTRIES];
    logic [ADDR_W-1:0]                     tgt_q  [ENTRIES];
    logic [MAX_INSN-1:0][INSN_W-1:0]       ins_q  [ENTRIES];

    logic [SET_W-1:0]  fset;
    logic [TAG_W-1:0]  ftag;
    logic [MAX_BR-1:0] fmask;
    logic [WAYS-1:0]   same;
    logic              wway;
    logic [E_W-1:0]    went;

    assign fset = fill_addr[SET_W-1:0];
    assign ftag = fill_addr[ADDR_W-1:SET_W];
    assign went = {fset, wway};

    // Mask of the direction bits that the incoming trace actually uses.
    always_comb begin
        for (int i = 0; i < MAX_BR; i++) fmask[i] = (i < int'(fill_nbr));
    end

    for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
        logic [E_W-1:0]    fe;
        logic [E_W-1:0]    re;
        logic [MAX_BR-1:0] ddiff;
        assign fe    = {fset, 1'(gw)};
        assign re    = {rd_set, 1'(gw)};
        assign ddiff = (dirs_q[fe] ^ fill_dirs) & fmask;
        // Detect an existing line with the same start and path as the fill.
        assign same[gw] = vld_q[fe] && (tag_q[fe] == ftag) &&
                          (nbr_q[fe] == fill_nbr) && (ddiff == '0);
        // Present the looked-up set's line in this way.
        assign rd_vld[gw]   = vld_q[re];
        assign rd_tag[gw]   = tag_q[re];
        assign rd_cnt[gw]   = cnt_q[re];
        assign rd_nbr[gw]   = nbr_q[re];
        assign rd_dirs[gw]  = dirs_q[re];
        assign rd_bpos[gw]  = bpos_q[re];
        assign rd_alt[gw]   = alt_q[re];
        assign rd_fall[gw]  = fall_q[re];
        assign rd_tgt[gw]   = tgt_q[re];
        assign rd_insns[gw] = ins_q[re];
    end

    // Choose the way a fill writes: same path, then invalid, then LRU.
    always_comb begin
        if (same[0])                 wway = 1'b0;
        else if (same[1])            wway = 1'b1;
        else if (!vld_q[{fset, 1'b0}]) wway = 1'b0;
        else if (!vld_q[{fset, 1'b1}]) wway = 1'b1;
        else                         wway = lru_q[fset];
    end

    // Write trace contents on a fill (data needs no reset).
    always_ff @(posedge clk) begin
        if (fill_valid) begin
            tag_q[went]  <= ftag;
            cnt_q[went]  <= fill_count;
            nbr_q[went]  <= fill_nbr;
            dirs_q[went] <= fill_dirs;
            bpos_q[went] <= fill_bpos;
            alt_q[went]  <= fill_alt;
            fall_q[went] <= fill_fall;
            tgt_q[went]  <= fill_tgt;
            ins_q[went]  <= fill_insns;
        end
    end

    // Track valid bits; reset empties the array.
    always_ff @(posedge clk) begin
        if (!rst_n)          vld_q <= '0;
        else if (fill_valid) vld_q[went] <= 1'b1;
    end

    // Point each set's LRU bit away from the way last touched; fill wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            if (lru_upd)    lru_q[lru_set] <= ~lru_way;
            if (fill_valid) lru_q[fset]    <= ~wway;
        end
    end

    assert_fill_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> vld_q[$past(went)]);
    assert_lru_away_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (lru_q[$past(fset)] != $past(wway)));
endmodule

// File: rtl/tc_way_match.sv
// Compares one way's line with a lookup: tag match, count of leading
// branches whose stored direction agrees with the prediction, and the
// number of instructions that way would deliver.
// Assumes branch positions are ascending and below the stored count.
module tc_way_match #(
    parameter int ADDR_W   = 16,
    parameter int MAX_INSN = 16,
    parameter int MAX_BR   = 3,
    parameter int SETS     = 16
) (
    input  logic                                    st_vld,
    input  logic [ADDR_W-$clog2(SETS)-1:0]          st_tag,
    input  logic [ADDR_W-$clog2(SETS)-1:0]          lk_tag,
    input  logic [$clog2(MAX_INSN+1)-1:0]           st_cnt,
    input  logic [$clog2(MAX_BR+1)-1:0]             st_nbr,
    input  logic [MAX_BR-1:0]                       st_dirs,
    input  logic [MAX_BR-1:0][$clog2(MAX_INSN)-1:0] st_bpos,
    input  logic [MAX_BR-1:0]                       pred,
    output logic                                    m_hit,
    output logic                                    m_full,
    output logic [$clog2(MAX_BR+1)-1:0]             m_agree,
    output logic [$clog2(MAX_INSN+1)-1:0]           m_cnt
);
    localparam int CNT_W = $clog2(MAX_INSN + 1);
    localparam int K_W   = $clog2(MAX_BR + 1);

    // Find the first disagreeing branch and the delivered length.
    always_comb begin
        logic         full;
        logic [K_W-1:0] agree;
        logic [CNT_W-1:0] cnt;
        full  = 1'b1;
        agree = st_nbr;
        for (int i = 0; i < MAX_BR; i++) begin
            if (full && (i < int'(st_nbr)) && (st_dirs[i] != pred[i])) begin
                full  = 1'b0;
                agree = K_W'(i);
            end
        end
        cnt = st_cnt;
        for (int i = 0; i < MAX_BR; i++) begin
            if (!full && (K_W'(i) == agree)) cnt = CNT_W'(st_bpos[i]) + CNT_W'(1);
        end
        m_hit   = st_vld && (st_tag == lk_tag);
        m_full  = full;
        m_agree = agree;
        m_cnt   = cnt;
    end
endmodule

// File: rtl/tc_select.sv
// Picks the answering way (full over partial, more agreeing branches,
// then way 0), and forms kind, count, next address and masked payload.
module tc_select
    import tc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int INSN_W   = 32,
    parameter int MAX_INSN = 16,
    parameter int MAX_BR   = 3
) (
    input  logic [1:0]                              m_hit,
    input  logic [1:0]                              m_full,
    input  logic [1:0][$clog2(MAX_BR+1)-1:0]        m_agree,
    input  logic [1:0][$clog2(MAX_INSN+1)-1:0]      m_cnt,
    input  logic [1:0][$clog2(MAX_INSN+1)-1:0]      rd_cnt,
    input  logic [1:0][$clog2(MAX_BR+1)-1:0]        rd_nbr,
    input  logic [1:0][MAX_BR-1:0]                  rd_dirs,
    input  logic [1:0][MAX_BR-1:0][$clog2(MAX_INSN)-1:0] rd_bpos,
    input  logic [1:0][MAX_BR-1:0][ADDR_W-1:0]      rd_alt,
    input  logic [1:0][ADDR_W-1:0]                  rd_fall,
    input  logic [1:0][ADDR_W-1:0]                  rd_tgt,
    input  logic [1:0][MAX_INSN-1:0][INSN_W-1:0]    rd_insns,
    output lk_kind_e                                kind,
    output logic                                    way,
    output logic [$clog2(MAX_INSN+1)-1:0]           cnt,
    output logic [ADDR_W-1:0]                       nxt,
    output logic [MAX_INSN-1:0][INSN_W-1:0]         insns
);
    localparam int CNT_W = $clog2(MAX_INSN + 1);
    localparam int K_W   = $clog2(MAX_BR + 1);

    // Rank the ways and classify the outcome.
    always_comb begin
        way = 1'b0;
        if (m_hit[1] && (!m_hit[0] ||
            ({m_full[1], m_agree[1]} > {m_full[0], m_agree[0]}))) way = 1'b1;
        if (m_hit == 2'b00)  kind = LK_MISS;
        else if (m_full[way]) kind = LK_FULL;
        else                 kind = LK_PART;
        cnt = (kind == LK_MISS) ? '0 : m_cnt[way];
    end

    // Choose the next fetch address for the delivered path.
    always_comb begin
        nxt = '0;
        if (kind == LK_FULL) begin
            nxt = rd_fall[way];
            for (int i = 0; i < MAX_BR; i++) begin
                if ((int'(rd_nbr[way]) == i + 1) && rd_dirs[way][i] &&
                    (CNT_W'(rd_bpos[way][i]) + CNT_W'(1) == rd_cnt[way]))
                    nxt = rd_tgt[way];
            end
        end else if (kind == LK_PART) begin
            for (int i = 0; i < MAX_BR; i++) begin
                if (K_W'(i) == m_agree[way]) nxt = rd_alt[way][i];
            end
        end
    end

    // Zero every slot past the delivered count.
    always_comb begin
        for (int i = 0; i < MAX_INSN; i++)
            insns[i] = (i < int'(cnt)) ? rd_insns[way][i] : '0;
    end
endmodule

// File: rtl/trace_lookup.sv
// Two-way path-associative trace lookup with partial hits.
// The fetch address picks a set; tag and predicted directions pick the
// line. The result is registered: one cycle of latency. The array is read
// before a same-cycle fill is written.
module trace_lookup
    import tc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int INSN_W   = 32,
    parameter int MAX_INSN = 16,
    parameter int MAX_BR   = 3,
    parameter int SETS     = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 lk_valid,
    input  logic [ADDR_W-1:0]                    lk_addr,
    input  logic [MAX_BR-1:0]                    lk_pred,
    input  logic                                 fill_valid,
    input  logic [ADDR_W-1:0]                    fill_addr,
    input  logic [$clog2(MAX_INSN+1)-1:0]        fill_count,
    input  logic [$clog2(MAX_BR+1)-1:0]          fill_nbr,
    input  logic [MAX_BR-1:0]                    fill_dirs,
    input  logic [MAX_BR*$clog2(MAX_INSN)-1:0]   fill_bpos,
    input  logic [MAX_BR*ADDR_W-1:0]             fill_alt,
    input  logic [ADDR_W-1:0]                    fill_fall,
    input  logic [ADDR_W-1:0]                    fill_tgt,
    input  logic [MAX_INSN*INSN_W-1:0]           fill_insns,
    output logic                                 res_valid,
    output logic                                 res_hit,
    output logic                                 res_partial,
    output logic                                 res_miss,
    output logic                                 res_way,
    output logic [$clog2(MAX_INSN+1)-1:0]        res_count,
    output logic [ADDR_W-1:0]                    res_next,
    output logic [MAX_INSN*INSN_W-1:0]           res_insns
);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int CNT_W = $clog2(MAX_INSN + 1);
    localparam int IDX_W = $clog2(MAX_INSN);
    localparam int K_W   = $clog2(MAX_BR + 1);

    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    assign lk_set = lk_addr[SET_W-1:0];
    assign lk_tag = lk_addr[ADDR_W-1:SET_W];

    logic [1:0]                          rd_vld;
    logic [1:0][TAG_W-1:0]               rd_tag;
    logic [1:0][CNT_W-1:0]               rd_cnt;
    logic [1:0][K_W-1:0]                 rd_nbr;
    logic [1:0][MAX_BR-1:0]              rd_dirs;
    logic [1:0][MAX_BR-1:0][IDX_W-1:0]   rd_bpos;
    logic [1:0][MAX_BR-1:0][ADDR_W-1:0]  rd_alt;
    logic [1:0][ADDR_W-1:0]              rd_fall;
    logic [1:0][ADDR_W-1:0]              rd_tgt;
    logic [1:0][MAX_INSN-1:0][INSN_W-1:0] rd_insns;

    logic [1:0]              m_hit;
    logic [1:0]              m_full;
    logic [1:0][K_W-1:0]     m_agree;
    logic [1:0][CNT_W-1:0]   m_cnt;

    lk_kind_e                       s_kind;
    logic                           s_way;
    logic [CNT_W-1:0]               s_cnt;
    logic [ADDR_W-1:0]              s_nxt;
    logic [MAX_INSN-1:0][INSN_W-1:0] s_insns;

    tc_store #(
        .ADDR_W(ADDR_W), .INSN_W(INSN_W), .MAX_INSN(MAX_INSN),
        .MAX_BR(MAX_BR), .SETS(SETS)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .rd_set(lk_set),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_count(fill_count),
        .fill_nbr(fill_nbr), .fill_dirs(fill_dirs), .fill_bpos(fill_bpos),
        .fill_alt(fill_alt), .fill_fall(fill_fall), .fill_tgt(fill_tgt),
        .fill_insns(fill_insns),
        .lru_upd(lk_valid && (s_kind != LK_MISS)), .lru_set(lk_set), .lru_way(s_way),
        .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_cnt(rd_cnt), .rd_nbr(rd_nbr),
        .rd_dirs(rd_dirs), .rd_bpos(rd_bpos), .rd_alt(rd_alt),
        .rd_fall(rd_fall), .rd_tgt(rd_tgt), .rd_insns(rd_insns)
    );

    for (genvar gw = 0; gw < 2; gw++) begin : g_match
        tc_way_match #(
            .ADDR_W(ADDR_W), .MAX_INSN(MAX_INSN), .MAX_BR(MAX_BR), .SETS(SETS)
        ) u_match (
            .st_vld(rd_vld[gw]), .st_tag(rd_tag[gw]), .lk_tag(lk_tag),
            .st_cnt(rd_cnt[gw]), .st_nbr(rd_nbr[gw]), .st_dirs(rd_dirs[gw]),
            .st_bpos(rd_bpos[gw]), .pred(lk_pred),
            .m_hit(m_hit[gw]), .m_full(m_full[gw]),
            .m_agree(m_agree[gw]), .m_cnt(m_cnt[gw])
        );
    end

    tc_select #(
        .ADDR_W(ADDR_W), .INSN_W(INSN_W), .MAX_INSN(MAX_INSN), .MAX_BR(MAX_BR)
    ) u_select (
        .m_hit(m_hit), .m_full(m_full), .m_agree(m_agree), .m_cnt(m_cnt),
        .rd_cnt(rd_cnt), .rd_nbr(rd_nbr), .rd_dirs(rd_dirs), .rd_bpos(rd_bpos),
        .rd_alt(rd_alt), .rd_fall(rd_fall), .rd_tgt(rd_tgt), .rd_insns(rd_insns),
        .kind(s_kind), .way(s_way), .cnt(s_cnt), .nxt(s_nxt), .insns(s_insns)
    );

    // Register the lookup result; idle cycles present an all-zero result.
    always_ff @(posedge clk) begin
        if (!rst_n || !lk_valid) begin
            res_valid   <= 1'b0;
            res_hit     <= 1'b0;
            res_partial <= 1'b0;
            res_miss    <= 1'b0;
            res_way     <= 1'b0;
            res_count   <= '0;
            res_next    <= '0;
            res_insns   <= '0;
        end else begin
            res_valid   <= 1'b1;
            res_hit     <= (s_kind == LK_FULL);
            res_partial <= (s_kind == LK_PART);
            res_miss    <= (s_kind == LK_MISS);
            res_way     <= s_way;
            res_count   <= s_cnt;
            res_next    <= s_nxt;
            res_insns   <= s_insns;
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid && !res_hit && !res_partial && !res_miss);
    assert_one_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_hit, res_partial, res_miss}) == 1));
    assert_miss_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (res_count == '0) && (res_next == '0) && (res_insns == '0));
    assert_hit_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit || res_partial) |-> (res_count != '0));
endmodule

// File: tb/tb_trace_lookup.sv
module tb_trace_lookup;
    localparam int ADDR_W = 16, INSN_W = 32, MAX_INSN = 16, MAX_BR = 3, SETS = 16;
    localparam int CNT_W = $clog2(MAX_INSN + 1);
    localparam int IDX_W = $clog2(MAX_INSN);
    localparam int K_W   = $clog2(MAX_BR + 1);
    localparam int PW    = MAX_INSN * INSN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic [MAX_BR-1:0] lk_pred = '0;
    logic fill_valid = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [CNT_W-1:0] fill_count = '0;
    logic [K_W-1:0] fill_nbr = '0;
    logic [MAX_BR-1:0] fill_dirs = '0;
    logic [MAX_BR*IDX_W-1:0] fill_bpos = '0;
    logic [MAX_BR*ADDR_W-1:0] fill_alt = '0;
    logic [ADDR_W-1:0] fill_fall = '0;
    logic [ADDR_W-1:0] fill_tgt = '0;
    logic [PW-1:0] fill_insns = '0;
    logic res_valid, res_hit, res_partial, res_miss, res_way;
    logic [CNT_W-1:0] res_count;
    logic [ADDR_W-1:0] res_next;
    logic [PW-1:0] res_insns;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    trace_lookup dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_pred(lk_pred), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_count(fill_count), .fill_nbr(fill_nbr), .fill_dirs(fill_dirs),
        .fill_bpos(fill_bpos), .fill_alt(fill_alt), .fill_fall(fill_fall),
        .fill_tgt(fill_tgt), .fill_insns(fill_insns), .res_valid(res_valid),
        .res_hit(res_hit), .res_partial(res_partial), .res_miss(res_miss),
        .res_way(res_way), .res_count(res_count), .res_next(res_next),
        .res_insns(res_insns)
    );

    // Expected payload: slot i = {line address, line id, i}, zero past count.
    function automatic logic [PW-1:0] payload(input logic [15:0] a, input logic [7:0] id,
                                              input int n);
        logic [PW-1:0] v;
        v = '0;
        for (int i = 0; i < n; i++) v[i*INSN_W +: INSN_W] = {a, id, 8'(i)};
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // kind: 0 miss, 1 partial, 2 full
    task automatic check_res(input string req, input int kind, input int cnt,
                             input bit way, input logic [15:0] nxt,
                             input logic [15:0] a, input logic [7:0] id);
        logic [2:0] fl, efl;
        logic [PW-1:0] ep;
        fl  = {res_hit, res_partial, res_miss};
        efl = (kind == 2) ? 3'b100 : (kind == 1) ? 3'b010 : 3'b001;
        ep  = (kind == 0) ? '0 : payload(a, id, cnt);
        chk(res_valid && fl == efl, req, "flags", PW'({res_valid, fl}), PW'({1'b1, efl}));
        chk(res_count == CNT_W'(cnt), req, "count", PW'(res_count), PW'(cnt));
        if (kind != 0) chk(res_way == way, req, "way", PW'(res_way), PW'(way));
        chk(res_next == nxt, req, "next", PW'(res_next), PW'(nxt));
        chk(res_insns == ep, req, "insns", res_insns, ep);
    endtask

    task automatic set_fill(input logic [15:0] a, input logic [7:0] id, input int n,
                            input int nb, input logic [2:0] d,
                            input int p0, input int p1, input int p2,
                            input logic [15:0] a0, input logic [15:0] a1,
                            input logic [15:0] a2, input logic [15:0] fa,
                            input logic [15:0] tg);
        fill_valid = 1'b1;
        fill_addr  = a;
        fill_count = CNT_W'(n);
        fill_nbr   = K_W'(nb);
        fill_dirs  = d;
        fill_bpos  = {IDX_W'(p2), IDX_W'(p1), IDX_W'(p0)};
        fill_alt   = {a2, a1, a0};
        fill_fall  = fa;
        fill_tgt   = tg;
        fill_insns = payload(a, id, n);
    endtask

    task automatic do_fill(input logic [15:0] a, input logic [7:0] id, input int n,
                           input int nb, input logic [2:0] d,
                           input int p0, input int p1, input int p2,
                           input logic [15:0] a0, input logic [15:0] a1,
                           input logic [15:0] a2, input logic [15:0] fa,
                           input logic [15:0] tg);
        @(negedge clk);
        set_fill(a, id, n, nb, d, p0, p1, p2, a0, a1, a2, fa, tg);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic look(input logic [15:0] a, input logic [2:0] p);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        lk_pred  = p;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [15:0] addr;
        logic [2:0]  pred;
        logic [1:0]  kind;
        logic [4:0]  cnt;
        logic        way;
        logic [15:0] nxt;
        logic [7:0]  id;
    } vec_t;

    // Lookups against lines A (0x13 w0), B (0x13 w1), C (0x25 w0), D (0x45 w1).
    localparam vec_t VECS [11] = '{
        '{16'h0013, 3'b101, 2'd2, 5'd12, 1'b0, 16'h0500, 8'd1}, // R3 R5 R7 full beats partial
        '{16'h0013, 3'b011, 2'd2, 5'd9,  1'b1, 16'h0510, 8'd2}, // R7 R8
        '{16'h0013, 3'b111, 2'd2, 5'd9,  1'b1, 16'h0510, 8'd2}, // R8 unused prediction bit
        '{16'h0013, 3'b001, 2'd1, 5'd12, 1'b0, 16'h0300, 8'd1}, // R4 R6 R7 more agreement wins
        '{16'h0013, 3'b000, 2'd1, 5'd3,  1'b0, 16'h0100, 8'd1}, // R4 R7 tie goes to way 0
        '{16'h0023, 3'b000, 2'd0, 5'd0,  1'b0, 16'h0000, 8'd0}, // R1 other tag same set
        '{16'h0025, 3'b010, 2'd2, 5'd16, 1'b0, 16'h0035, 8'd3}, // R3 R8 full-length no branch
        '{16'h0045, 3'b000, 2'd2, 5'd5,  1'b1, 16'h004A, 8'd4}, // R5 line not ending on branch
        '{16'h0045, 3'b001, 2'd1, 5'd2,  1'b1, 16'h0777, 8'd4}, // R4 R6
        '{16'h0035, 3'b000, 2'd0, 5'd0,  1'b0, 16'h0000, 8'd0}, // R1
        '{16'h0000, 3'b111, 2'd0, 5'd0,  1'b0, 16'h0000, 8'd0}  // R1 empty set
    };

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 outputs cleared during reset
        chk(!res_valid && !res_hit && !res_partial && !res_miss && res_count == '0,
            "R11", "reset outputs", PW'({res_valid, res_hit, res_partial, res_miss}), '0);
        rst_n = 1'b1;

        // R10 fills: invalid way 0 first, then way 1
        do_fill(16'h0013, 8'd1, 12, 3, 3'b101, 2, 6, 11, 16'h0100, 16'h0200, 16'h0300, 16'h0400, 16'h0500);
        do_fill(16'h0013, 8'd2, 9, 2, 3'b011, 3, 8, 0, 16'h0110, 16'h0210, 16'h0000, 16'h0410, 16'h0510);
        do_fill(16'h0025, 8'd3, 16, 0, 3'b000, 0, 0, 0, 16'h0, 16'h0, 16'h0, 16'h0035, 16'h0999);
        do_fill(16'h0045, 8'd4, 5, 1, 3'b000, 1, 0, 0, 16'h0777, 16'h0, 16'h0, 16'h004A, 16'h0999);

        foreach (VECS[i]) begin
            look(VECS[i].addr, VECS[i].pred);
            check_res(VECS[i].kind == 0 ? "R1" : VECS[i].kind == 1 ? "R4" : "R3",
                      int'(VECS[i].kind), int'(VECS[i].cnt), VECS[i].way,
                      VECS[i].nxt, VECS[i].addr, VECS[i].id);
        end

        // R2 idle cycle gives no result
        @(negedge clk);
        chk(!res_valid && !res_hit && !res_partial && !res_miss, "R2", "idle",
            PW'({res_valid, res_hit, res_partial, res_miss}), '0);

        // R9 same path as A overwrites way 0 although LRU points at way 1
        do_fill(16'h0013, 8'd5, 6, 3, 3'b101, 0, 2, 5, 16'h0130, 16'h0230, 16'h0330, 16'h0430, 16'h0600);
        look(16'h0013, 3'b101);
        check_res("R9", 2, 6, 1'b0, 16'h0600, 16'h0013, 8'd5);
        look(16'h0013, 3'b011);
        check_res("R9", 2, 9, 1'b1, 16'h0510, 16'h0013, 8'd2);

        // R10 new path evicts LRU way 0
        do_fill(16'h0013, 8'd6, 1, 1, 3'b000, 0, 0, 0, 16'h07A0, 16'h0, 16'h0, 16'h0700, 16'h07B0);
        look(16'h0013, 3'b000);
        check_res("R10", 2, 1, 1'b0, 16'h0700, 16'h0013, 8'd6);
        look(16'h0013, 3'b101);
        check_res("R10", 1, 9, 1'b1, 16'h0210, 16'h0013, 8'd2);
        // R10 last hit was way 1, so the next fill replaces way 0
        do_fill(16'h0013, 8'd7, 2, 2, 3'b000, 0, 1, 0, 16'h07D0, 16'h07E0, 16'h0, 16'h07C0, 16'h07F0);
        look(16'h0013, 3'b000);
        check_res("R10", 2, 2, 1'b0, 16'h07C0, 16'h0013, 8'd7);
        look(16'h0013, 3'b011);
        check_res("R10", 2, 9, 1'b1, 16'h0510, 16'h0013, 8'd2);

        // R12 lookup colliding with a fill of the same line sees old data
        @(negedge clk);
        set_fill(16'h0045, 8'd8, 3, 1, 3'b000, 2, 0, 0, 16'h0888, 16'h0, 16'h0, 16'h004B, 16'h0099);
        lk_valid = 1'b1;
        lk_addr  = 16'h0045;
        lk_pred  = 3'b000;
        @(negedge clk);
        fill_valid = 1'b0;
        lk_valid   = 1'b0;
        check_res("R12", 2, 5, 1'b1, 16'h004A, 16'h0045, 8'd4);
        look(16'h0045, 3'b000);
        check_res("R12", 2, 3, 1'b1, 16'h004B, 16'h0045, 8'd8);

        // R11 reset invalidates every line
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        look(16'h0013, 3'b011);
        check_res("R11", 0, 0, 1'b0, 16'h0000, 16'h0013, 8'd0);
        look(16'h0045, 3'b000);
        check_res("R11", 0, 0, 1'b0, 16'h0000, 16'h0045, 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule